// File: doc/BRIEF.md
# Delayed Transaction Request Queue

This block sits on one direction of a bus bridge and keeps track of non-posted requests (I/O reads and writes, configuration reads and writes, memory reads) that the bridge has refused with a retry so that it can run them on the far bus. Each first attempt is recorded. Later attempts that carry the same command and address are recognised and do not produce a second record. The initiator keeps repeating the access until the far-side transfer has finished. At that point the repeat is answered with a data-transfer acknowledge, and the record is released.

Records leave toward a far-bus master strictly from the oldest record, one at a time, through a valid/ready handshake. The master reports each attempt as either retried by the far target or completed. The block counts far-side retries and abandons a record once a configurable limit is reached. After a completion reaches the oldest slot, a discard timer runs, and the completion is dropped if the initiator does not come back in time. Both events produce a one-cycle system-error pulse. The retry limit and the timer preload are inputs, so that small values can be used in tests.

Top module: `drq_queue`

## Requirements
- R1: A request that matches no stored record, arriving while fewer than DEPTH records are stored, is answered with retry and appended. When it becomes the oldest record, the issue port shows its command, address, address parity, data, byte enables (active low) and data parity unchanged.
- R2: A request whose aliased command and address equal those of a stored record never creates a second record, whatever its data.
- R3: No more than DEPTH records are held. A new request that arrives while DEPTH are stored is answered with retry and is never issued.
- R4: A repeat of a stored request whose far-side transfer is pending or in progress is answered with retry.
- R5: For write commands (command bit 0 = 1), a repeat matches only with identical byte enables and identical data in every byte whose enable bit is 0. Bytes whose enable bit is 1 are not compared.
- R6: Commands 4'h6, 4'hC and 4'hE count as one command for matching.
- R7: A matching repeat of the oldest record, once that record is completed, is answered with trdy and no retry. stop is raised together with trdy exactly when req_multi is set. The record is then released.
- R8: A far-side retry returns the oldest record to the issued-again state. The retry that brings the total for that record to cfg_retry_limit instead releases the record and pulses err_retry_limit for one cycle.
- R9: A completion at the oldest slot that is not collected is released. err_discard pulses in the cycle that starts cfg_discard_init+1 clock edges after the completion edge, and a collection on any earlier cycle takes precedence.
- R10: iss_valid is high only while the oldest record waits to be issued. While it is high and iss_ready is low, the record stays presented unchanged. Records are issued in arrival order.
- R11: Every request cycle gets exactly one answer, rsp_valid with exactly one of rsp_retry or rsp_trdy, in the cycle after the request. No answer is given without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An initiator access is presented this cycle |
| req_cmd | input | 4 | Bus command of the access |
| req_addr | input | 32 | Address of the access |
| req_addr_par | input | 1 | Address parity |
| req_data | input | 32 | First data word (writes) |
| req_be_n | input | 4 | Byte enables, active low |
| req_data_par | input | 1 | Data parity |
| req_multi | input | 1 | Initiator wants more than one data word |
| rsp_valid | output | 1 | Answer to last cycle's access |
| rsp_retry | output | 1 | Answer is retry |
| rsp_trdy | output | 1 | Answer is data transferred |
| rsp_stop | output | 1 | Disconnect together with trdy |
| iss_valid | output | 1 | Oldest record waits to be issued |
| iss_ready | input | 1 | Far-bus master accepts the record |
| iss_cmd | output | 4 | Issued command |
| iss_addr | output | 32 | Issued address |
| iss_addr_par | output | 1 | Issued address parity |
| iss_data | output | 32 | Issued data |
| iss_be_n | output | 4 | Issued byte enables |
| iss_data_par | output | 1 | Issued data parity |
| tgt_valid | input | 1 | Outcome of the issued attempt |
| tgt_retry | input | 1 | Outcome was a far-side retry (else completed) |
| cfg_retry_limit | input | CNT_W | Far-side retries allowed per record |
| cfg_discard_init | input | CNT_W | Discard timer preload |
| err_retry_limit | output | 1 | Pulse: record abandoned after retries |
| err_discard | output | 1 | Pulse: uncollected completion dropped |

## Verification
On every cycle the assertions hold the answer protocol: one answer per request in the next cycle, trdy and retry mutually exclusive, stop only with trdy and only for multi-word requests. They also hold the issue side, with a presented record stable while stalled, issue only from a non-empty store and occupancy never above DEPTH, and they keep the two error pulses apart. Duplicate suppression, byte-masked write matching, command aliasing, arrival ordering and the exact retry-limit and discard-timer cycles depend on the stored contents and their history. These are shown only by the bench's scenarios, where a behavioural queue model is compared on every clock.

// File: rtl/drq_pkg.sv
package drq_pkg;
    localparam int CMD_W  = 4;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    typedef enum logic [1:0] {
        HS_PEND = 2'd0,
        HS_BUSY = 2'd1,
        HS_DONE = 2'd2
    } head_st_e;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [ADDR_W-1:0] addr;
        logic              addr_par;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be_n;
        logic              data_par;
    } dreq_t;

    // The three memory read flavours share one matching class.
    function automatic logic [CMD_W-1:0] cmd_class(input logic [CMD_W-1:0] c);
        if (c == 4'h6 || c == 4'hC || c == 4'hE) return 4'h6;
        return c;
    endfunction

    function automatic logic lanes_equal(input logic [DATA_W-1:0] a,
                                         input logic [DATA_W-1:0] b,
                                         input logic [BE_W-1:0]   be_n);
        for (int k = 0; k < BE_W; k++) begin
            if (!be_n[k] && (a[8*k +: 8] != b[8*k +: 8])) return 1'b0;
        end
        return 1'b1;
    endfunction
endpackage

// File: rtl/drq_match.sv
module drq_match import drq_pkg::*; #(
    parameter int DEPTH = 4,
    parameter int PTR_W = 2
) (
    input  dreq_t [DEPTH-1:0] ent,
    input  logic  [DEPTH-1:0] live,
    input  dreq_t             probe,
    output logic              dup,
    output logic [PTR_W-1:0]  dup_idx,
    output logic              data_ok
);
    logic [DEPTH-1:0] key_eq;
    logic [DEPTH-1:0] body_eq;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign key_eq[g] = live[g]
                         && (cmd_class(ent[g].cmd) == cmd_class(probe.cmd))
                         && (ent[g].addr == probe.addr);
        assign body_eq[g] = !probe.cmd[0]
                          || ((ent[g].be_n == probe.be_n)
                              && lanes_equal(ent[g].data, probe.data, probe.be_n));
    end

    always_comb begin
        dup_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (key_eq[i]) dup_idx = PTR_W'(i);
        end
        dup     = |key_eq;
        data_ok = body_eq[dup_idx];
    end
endmodule

// File: rtl/drq_ager.sv
module drq_ager #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_retry_limit,
    input  logic [CNT_W-1:0] cfg_discard_init,
    input  logic             retry_ev,
    input  logic             done_ev,
    output logic             retry_hit,
    output logic             discard_hit
);
    typedef struct packed {
        logic [CNT_W-1:0] rcnt;
        logic [CNT_W-1:0] tmr;
    } age_t;

    age_t q, d;

    assign retry_hit   = retry_ev && (({1'b0, q.rcnt} + 1'b1) >= {1'b0, cfg_retry_limit});
    assign discard_hit = (q.tmr == '0);

    always_comb begin
        d = q;
        if (retry_ev)     d.rcnt = retry_hit ? '0 : q.rcnt + 1'b1;
        else if (done_ev) d.rcnt = '0;
        if (done_ev)              d.tmr = cfg_discard_init;
        else if (q.tmr != '0)     d.tmr = q.tmr - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/drq_queue.sv
module drq_queue import drq_pkg::*; #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_addr_par,
    input  logic [DATA_W-1:0] req_data,
    input  logic [BE_W-1:0]   req_be_n,
    input  logic              req_data_par,
    input  logic              req_multi,
    output logic              rsp_valid,
    output logic              rsp_retry,
    output logic              rsp_trdy,
    output logic              rsp_stop,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [CMD_W-1:0]  iss_cmd,
    output logic [ADDR_W-1:0] iss_addr,
    output logic              iss_addr_par,
    output logic [DATA_W-1:0] iss_data,
    output logic [BE_W-1:0]   iss_be_n,
    output logic              iss_data_par,
    input  logic              tgt_valid,
    input  logic              tgt_retry,
    input  logic [CNT_W-1:0]  cfg_retry_limit,
    input  logic [CNT_W-1:0]  cfg_discard_init,
    output logic              err_retry_limit,
    output logic              err_discard
);
    // DEPTH must be a power of two so that the pointers wrap naturally.
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    typedef logic [PTR_W-1:0] ptr_t;
    typedef logic [PTR_W:0]   occ_t;

    typedef struct packed {
        dreq_t [DEPTH-1:0] ent;
        ptr_t              head;
        ptr_t              tail;
        occ_t              count;
        head_st_e          hst;
        logic              rsp_valid;
        logic              rsp_retry;
        logic              rsp_trdy;
        logic              rsp_stop;
        logic              err_rl;
        logic              err_dc;
    } state_t;

    state_t q, d;

    dreq_t            probe;
    logic [DEPTH-1:0] live;
    logic             dup, data_ok;
    ptr_t             dup_idx;
    logic             busy, done, retry_ev, done_ev, retry_hit, discard_hit;
    logic             pop, push, collect;
    occ_t             occupancy;

    assign probe = '{cmd: req_cmd, addr: req_addr, addr_par: req_addr_par,
                     data: req_data, be_n: req_be_n, data_par: req_data_par};

    for (genvar g = 0; g < DEPTH; g++) begin : g_live
        assign live[g] = {1'b0, ptr_t'(PTR_W'(g) - q.head)} < q.count;
    end

    drq_match #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_match (
        .ent     (q.ent),
        .live    (live),
        .probe   (probe),
        .dup     (dup),
        .dup_idx (dup_idx),
        .data_ok (data_ok)
    );

    assign busy     = (q.hst == HS_BUSY);
    assign done     = (q.hst == HS_DONE);
    assign retry_ev = busy && tgt_valid && tgt_retry;
    assign done_ev  = busy && tgt_valid && !tgt_retry;

    drq_ager #(.CNT_W(CNT_W)) u_ager (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_retry_limit  (cfg_retry_limit),
        .cfg_discard_init (cfg_discard_init),
        .retry_ev         (retry_ev),
        .done_ev          (done_ev),
        .retry_hit        (retry_hit),
        .discard_hit      (discard_hit)
    );

    always_comb begin
        d           = q;
        d.rsp_valid = req_valid;
        d.rsp_retry = 1'b0;
        d.rsp_trdy  = 1'b0;
        d.rsp_stop  = 1'b0;
        d.err_rl    = 1'b0;
        d.err_dc    = 1'b0;
        pop         = 1'b0;
        push        = 1'b0;
        collect     = 1'b0;

        if (q.hst == HS_PEND && q.count != '0 && iss_ready) d.hst = HS_BUSY;

        if (retry_ev) begin
            if (retry_hit) begin
                pop      = 1'b1;
                d.err_rl = 1'b1;
            end else begin
                d.hst = HS_PEND;
            end
        end else if (done_ev) begin
            d.hst = HS_DONE;
        end

        if (req_valid) begin
            if (dup && dup_idx == q.head && done && data_ok) begin
                collect    = 1'b1;
                pop        = 1'b1;
                d.rsp_trdy = 1'b1;
                d.rsp_stop = req_multi;
            end else begin
                d.rsp_retry = 1'b1;
                if (!dup && q.count < occ_t'(DEPTH)) push = 1'b1;
            end
        end

        if (done && !collect && discard_hit) begin
            pop      = 1'b1;
            d.err_dc = 1'b1;
        end

        if (pop) begin
            d.head = q.head + ptr_t'(1);
            d.hst  = HS_PEND;
        end
        if (push) begin
            d.ent[q.tail] = probe;
            d.tail        = q.tail + ptr_t'(1);
        end
        d.count = q.count + occ_t'(push) - occ_t'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign occupancy       = q.count;
    assign rsp_valid       = q.rsp_valid;
    assign rsp_retry       = q.rsp_retry;
    assign rsp_trdy        = q.rsp_trdy;
    assign rsp_stop        = q.rsp_stop;
    assign err_retry_limit = q.err_rl;
    assign err_discard     = q.err_dc;
    assign iss_valid       = (q.hst == HS_PEND) && (q.count != '0);
    assign iss_cmd         = q.ent[q.head].cmd;
    assign iss_addr        = q.ent[q.head].addr;
    assign iss_addr_par    = q.ent[q.head].addr_par;
    assign iss_data        = q.ent[q.head].data;
    assign iss_be_n        = q.ent[q.head].be_n;
    assign iss_data_par    = q.ent[q.head].data_par;
endmodule

// File: rtl/drq_checker.sv
module drq_checker #(
    parameter int DEPTH = 4,
    parameter int OCC_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_multi,
    input logic             rsp_valid,
    input logic             rsp_retry,
    input logic             rsp_trdy,
    input logic             rsp_stop,
    input logic             iss_valid,
    input logic             iss_ready,
    input logic [3:0]       iss_cmd,
    input logic [31:0]      iss_addr,
    input logic             tgt_valid,
    input logic             err_retry_limit,
    input logic             err_discard,
    input logic [OCC_W-1:0] occupancy
);
    p_resp_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_resp_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_resp_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_retry ^ rsp_trdy));
    p_stop_with_trdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_stop |-> rsp_trdy);
    p_stop_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_multi) |=> !rsp_stop);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= OCC_W'(DEPTH));
    p_issue_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_addr) && $stable(iss_cmd)));
    p_issue_nonempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (occupancy != '0));
    p_err_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_retry_limit && err_discard));
    p_retry_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_retry_limit |-> $past(tgt_valid));
    p_discard_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_discard |=> !err_discard);
endmodule

bind drq_queue drq_checker #(.DEPTH(DEPTH), .OCC_W(PTR_W + 1)) i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_multi       (req_multi),
    .rsp_valid       (rsp_valid),
    .rsp_retry       (rsp_retry),
    .rsp_trdy        (rsp_trdy),
    .rsp_stop        (rsp_stop),
    .iss_valid       (iss_valid),
    .iss_ready       (iss_ready),
    .iss_cmd         (iss_cmd),
    .iss_addr        (iss_addr),
    .tgt_valid       (tgt_valid),
    .err_retry_limit (err_retry_limit),
    .err_discard     (err_discard),
    .occupancy       (occupancy)
);

// File: tb/test_drq_queue.sv
module test_drq_queue;
    localparam int DEPTH = 4;
    localparam int CNT_W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_addr_par = 0, req_data_par = 0, req_multi = 0;
    logic [3:0]  req_cmd = 0, req_be_n = 0;
    logic [31:0] req_addr = 0, req_data = 0;
    logic        rsp_valid, rsp_retry, rsp_trdy, rsp_stop;
    logic        iss_valid, iss_addr_par, iss_data_par;
    logic        iss_ready = 0, tgt_valid = 0, tgt_retry = 0;
    logic [3:0]  iss_cmd, iss_be_n;
    logic [31:0] iss_addr, iss_data;
    logic [CNT_W-1:0] cfg_retry_limit = 100, cfg_discard_init = 1000;
    logic        err_retry_limit, err_discard;

    always #4 clk = ~clk;

    drq_queue #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_drq_queue (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
        .req_addr_par(req_addr_par), .req_data(req_data), .req_be_n(req_be_n),
        .req_data_par(req_data_par), .req_multi(req_multi),
        .rsp_valid(rsp_valid), .rsp_retry(rsp_retry), .rsp_trdy(rsp_trdy), .rsp_stop(rsp_stop),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_cmd(iss_cmd), .iss_addr(iss_addr),
        .iss_addr_par(iss_addr_par), .iss_data(iss_data), .iss_be_n(iss_be_n),
        .iss_data_par(iss_data_par),
        .tgt_valid(tgt_valid), .tgt_retry(tgt_retry),
        .cfg_retry_limit(cfg_retry_limit), .cfg_discard_init(cfg_discard_init),
        .err_retry_limit(err_retry_limit), .err_discard(err_discard)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct {
        logic [3:0]  cmd;
        logic [31:0] addr;
        logic        ap;
        logic [31:0] data;
        logic [3:0]  be;
        logic        dp;
    } m_ent_t;

    m_ent_t  mq[$];
    int      mst;        // 0 waiting, 1 in flight, 2 completed
    longint  mrc, mtmr;
    bit      e_rv, e_rr, e_rt, e_rs, e_erl, e_edc;
    bit      m_pop, m_push, m_coll, m_dm;
    int      m_hit, m_nst;

    function automatic logic [3:0] mclass(input logic [3:0] c);
        return (c == 4'h6 || c == 4'hC || c == 4'hE) ? 4'h6 : c;
    endfunction

    function automatic bit bytes_same(input logic [31:0] a, input logic [31:0] b,
                                      input logic [3:0] be_n);
        for (int k = 0; k < 4; k++)
            if (!be_n[k] && a[8*k +: 8] !== b[8*k +: 8]) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            mst = 0; mrc = 0; mtmr = 0;
            e_rv = 0; e_rr = 0; e_rt = 0; e_rs = 0; e_erl = 0; e_edc = 0;
        end else begin
            m_pop = 0; m_push = 0; m_coll = 0; m_hit = -1; m_dm = 0;
            e_rv = req_valid; e_rr = 0; e_rt = 0; e_rs = 0; e_erl = 0; e_edc = 0;
            m_nst = mst;
            if (mst == 0 && mq.size() > 0 && iss_ready) m_nst = 1;
            if (mst == 1 && tgt_valid) begin
                if (tgt_retry) begin
                    if (mrc + 1 >= longint'(cfg_retry_limit)) begin m_pop = 1; e_erl = 1; end
                    else begin mrc++; m_nst = 0; end
                end else begin
                    m_nst = 2; mtmr = cfg_discard_init; mrc = 0;
                end
            end
            if (req_valid) begin
                for (int j = 0; j < mq.size(); j++)
                    if (mclass(mq[j].cmd) == mclass(req_cmd) && mq[j].addr == req_addr) m_hit = j;
                if (m_hit >= 0)
                    m_dm = !req_cmd[0] || (mq[m_hit].be == req_be_n &&
                                           bytes_same(mq[m_hit].data, req_data, req_be_n));
                if (m_hit == 0 && mst == 2 && m_dm) begin
                    m_coll = 1; m_pop = 1; e_rt = 1; e_rs = req_multi;
                end else begin
                    e_rr = 1;
                    if (m_hit < 0 && mq.size() < DEPTH) m_push = 1;
                end
            end
            if (mst == 2 && !m_coll) begin
                if (mtmr == 0) begin m_pop = 1; e_edc = 1; end
                else mtmr--;
            end
            if (m_pop) begin void'(mq.pop_front()); m_nst = 0; mrc = 0; end
            if (m_push) mq.push_back('{req_cmd, req_addr, req_addr_par, req_data, req_be_n, req_data_par});
            mst = m_nst;
        end
    end

    // cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R11 rsp_valid", rsp_valid, e_rv);
            chk("R11 rsp_retry", rsp_retry, e_rr);
            chk("R7 rsp_trdy",  rsp_trdy,  e_rt);
            chk("R7 rsp_stop",  rsp_stop,  e_rs);
            chk("R8 err_retry_limit", err_retry_limit, e_erl);
            chk("R9 err_discard", err_discard, e_edc);
            chk("R10 iss_valid", iss_valid, (mq.size() > 0 && mst == 0));
            if (mq.size() > 0 && mst == 0) begin
                chk("R1 iss_cmd",  iss_cmd,  mq[0].cmd);
                chk("R1 iss_addr", iss_addr, mq[0].addr);
                chk("R1 iss_data", iss_data, mq[0].data);
                chk("R1 iss_be_n", iss_be_n, mq[0].be);
                chk("R1 iss_par",  {iss_addr_par, iss_data_par}, {mq[0].ap, mq[0].dp});
            end
        end
    end

    // ---------------- stimulus helpers (start and end at a negedge) ----------------
    task automatic send(input logic [3:0] c, input logic [31:0] a, input logic [31:0] dt,
                        input logic [3:0] be, input logic multi);
        req_valid = 1; req_cmd = c; req_addr = a; req_data = dt; req_be_n = be;
        req_multi = multi; req_addr_par = ^a; req_data_par = ^dt;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic issue_one();
        while (!iss_valid) @(negedge clk);
        iss_ready = 1;
        @(negedge clk);
        iss_ready = 0;
    endtask

    task automatic reply(input logic rt);
        tgt_valid = 1; tgt_retry = rt;
        @(negedge clk);
        tgt_valid = 0; tgt_retry = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] wa, wd;
        int waited;
        wa = 32'h1000_0040; wd = 32'hCAFE_0011;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R11 reset rsp_valid", rsp_valid, 0);
        chk("R10 reset iss_valid", iss_valid, 0);

        // capture of an I/O write with byte 3 disabled
        send(4'h3, wa, wd, 4'b1000, 1'b1);
        chk("R1 first answer retry", rsp_retry, 1);
        chk("R1 stored addr", iss_addr, wa);
        chk("R1 stored data", iss_data, wd);

        // repeat while waiting: retry, no second record
        send(4'h3, wa, wd, 4'b1000, 1'b1);
        chk("R4 repeat pending retry", rsp_retry, 1);

        issue_one();
        chk("R10 in flight not offered", iss_valid, 0);
        send(4'h3, wa, wd, 4'b1000, 1'b1);
        chk("R4 repeat in flight retry", rsp_retry, 1);
        reply(1'b1);
        chk("R8 reissue after far retry", iss_valid, 1);
        issue_one();
        reply(1'b0);

        // enabled byte differs: no match
        send(4'h3, wa, wd ^ 32'h0000_00FF, 4'b1000, 1'b1);
        chk("R5 enabled byte differs", rsp_retry, 1);
        chk("R2 no duplicate record", iss_valid, 0);
        // only the disabled byte differs: collected with disconnect
        send(4'h3, wa, wd ^ 32'hFF00_0000, 4'b1000, 1'b1);
        chk("R5 masked byte ignored", rsp_trdy, 1);
        chk("R7 stop for multi word", rsp_stop, 1);
        chk("R2 queue empty after collect", iss_valid, 0);

        // memory read aliasing
        send(4'hE, 32'h0000_8000, 0, 4'b0000, 1'b0);
        send(4'hC, 32'h0000_8000, 0, 4'b0000, 1'b0);
        chk("R6 alias is duplicate", rsp_retry, 1);
        issue_one();
        reply(1'b0);
        send(4'h6, 32'h0000_8000, 0, 4'b0000, 1'b0);
        chk("R6 alias collects", rsp_trdy, 1);
        chk("R7 no stop for single word", rsp_stop, 0);
        chk("R6 nothing left", iss_valid, 0);

        // fill beyond capacity, check arrival order
        for (int i = 0; i < DEPTH + 1; i++) send(4'hA, 32'h2000 + 4*i, 0, 4'b0000, 1'b0);
        chk("R3 overflow answered retry", rsp_retry, 1);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R10 arrival order", iss_addr, 32'h2000 + 4*i);
            issue_one();
            reply(1'b0);
            send(4'hA, 32'h2000 + 4*i, 0, 4'b0000, 1'b0);
            chk("R7 collect filled entry", rsp_trdy, 1);
        end
        chk("R3 overflow request never stored", iss_valid, 0);

        // retry limit
        cfg_retry_limit = 3;
        send(4'hB, 32'h0000_3000, 32'h1234_5678, 4'b0000, 1'b0);
        issue_one(); reply(1'b1);
        chk("R8 below limit no error", err_retry_limit, 0);
        issue_one(); reply(1'b1);
        issue_one(); reply(1'b1);
        chk("R8 limit reached error", err_retry_limit, 1);
        chk("R8 record dropped", iss_valid, 0);

        // discard timer
        cfg_discard_init = 5;
        send(4'h2, 32'h0000_4000, 0, 4'b0000, 1'b0);
        issue_one();
        reply(1'b0);
        waited = 0;
        while (!err_discard && waited < 50) begin @(negedge clk); waited++; end
        chk("R9 discard cycle", waited, 6);
        send(4'h2, 32'h0000_4000, 0, 4'b0000, 1'b0);
        chk("R9 late repeat retried", rsp_retry, 1);
        chk("R9 late repeat re-entered", iss_valid, 1);

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule